// File: doc/BRIEF.md
# Symmetric Low-Pass FIR Filter

This block is a linear-phase, low-pass finite impulse response filter in direct form. It takes signed 12-bit samples from an analog-to-digital converter and produces signed 14-bit samples for a digital-to-analog converter. Each output is the weighted sum of the newest input and the previous TAPS-1 inputs. The result never feeds back into the filter.

The coefficient set is mirror-symmetric. The two samples that share a coefficient are added first, so one multiplier serves each mirrored pair. A 7-tap filter therefore needs 4 multipliers. The coefficients are fixed at build time. A parameter sets their precision: 16 bits by default, or a coarser 8-bit set derived from the same base values. The output scaling follows the chosen precision.

The datapath is fully pipelined. A sample is accepted on every cycle in which `in_valid` is high, so `in_valid` can serve directly as a sample-rate clock enable. The stream has no back-pressure. The block has no ready signal, and it drops no sample. Every `out_valid` pulse carries a new result, and the consumer must take it in that cycle.

Top module: `sym_fir`

## Requirements
- R1: A synchronous reset clears every delay-line and pipeline register. In the cycle after a reset edge, `out_valid` is 0 and `out_data` is 0.
- R2: Every cycle with `in_valid` high produces exactly one `out_valid` pulse, five clock edges later. That pulse is seen in the fifth cycle after the accepting cycle. No pulse appears otherwise.
- R3: Cycles with `in_valid` low have no effect, whatever is on `in_data`. The stored history does not move, and `out_data` holds its last value until the next `out_valid`.
- R4: Let x[n-k] be the k-th most recent accepted sample, with k = 0 for the newest. Each output is acc = sum of c[k]·x[n-k] over k = 0..TAPS-1. The result is rounded as floor((acc + 2^(S-1)) / 2^S), where S = COEF_W − 2, and then saturated.
- R5: The default build uses TAPS = 7 and COEF_W = 16. Its coefficients are c = {-1200, 3000, 16000, 29936, 16000, 3000, -1200}, and S = 14.
- R6: With COEF_W = 8, each coefficient is floor((c16 + 128) / 256), giving {-5, 12, 63, 117, 63, 12, -5}, and S = 6.
- R7: Results above 8191 are output as 8191, and results below −8192 are output as −8192. The accumulator is wide enough that full-scale inputs of either sign saturate correctly and never wrap.
- R8: Mirrored taps share one coefficient. An impulse placed k samples back gives the same output as one placed TAPS−1−k samples back. For odd TAPS, the centre tap contributes alone with its own coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe / clock enable; accepts `in_data` this cycle |
| in_data | input | IN_W (12) | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new filtered sample |
| out_data | output | OUT_W (14) | Signed, rounded and saturated filter output |

## Verification
A corrupted delay-line entry stays in the filter for TAPS accepted samples. Every output during that span is wrong, and the first wrong output appears at the ports five cycles after the next accepted sample. A fault in the strobe pipeline shows at once as a missing, extra or shifted `out_valid` pulse against the five-edge latency. A wrong coefficient, pair pairing or rounding shift shows as a wrong value on the very next impulse output, and mirrored impulse positions then give different results. A narrowed accumulator or a wrong clamp shows only under full-scale alternating-sign inputs, where the output must pin to the rail instead of wrapping.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;

  // Width of the base coefficient set supplied to the filter.
  localparam int BASE_COEF_W = 16;

  // Reduce a base coefficient to coef_w bits: add half an LSB, then shift right arithmetically.
  function automatic int quant_coef(int base, int coef_w);
    if (coef_w >= BASE_COEF_W) return base;
    return (base + (1 <<< (BASE_COEF_W - coef_w - 1))) >>> (BASE_COEF_W - coef_w);
  endfunction

endpackage

// File: rtl/sym_fir_taps.sv
module sym_fir_taps #(
  parameter int IN_W = 12,
  parameter int TAPS = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   tap_valid,
  output logic signed [IN_W-1:0] taps [TAPS]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_valid <= 1'b0;
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
    end else begin
      tap_valid <= in_valid;
      if (in_valid) begin
        taps[0] <= in_data;
        for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
      end
    end
  end

  // R3: history moves only on an accepted sample
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> $stable(taps[TAPS-1]));

endmodule

// File: rtl/sym_fir_preadd.sv
module sym_fir_preadd #(
  parameter int IN_W = 12,
  parameter int TAPS = 7,
  localparam int HALF  = (TAPS + 1) / 2,
  localparam int NPAIR = TAPS / 2,
  localparam int PRE_W = IN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tap_valid,
  input  logic signed [IN_W-1:0]  taps [TAPS],
  output logic                    pre_valid,
  output logic signed [PRE_W-1:0] pre [HALF]
);

  always_ff @(posedge clk) begin
    if (rst) pre_valid <= 1'b0;
    else     pre_valid <= tap_valid;
  end

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst)            pre[j] <= '0;
      else if (tap_valid) pre[j] <= $signed({taps[j][IN_W-1], taps[j]})
                                  + $signed({taps[TAPS-1-j][IN_W-1], taps[TAPS-1-j]});
    end
  end

  if (TAPS % 2 == 1) begin : g_centre
    always_ff @(posedge clk) begin
      if (rst)            pre[NPAIR] <= '0;
      else if (tap_valid) pre[NPAIR] <= $signed({taps[NPAIR][IN_W-1], taps[NPAIR]});
    end
  end

endmodule

// File: rtl/sym_fir_mac.sv
module sym_fir_mac #(
  parameter int IN_W   = 12,
  parameter int TAPS   = 7,
  parameter int COEF_W = 16,
  parameter int BASE_COEF [TAPS] = '{-1200, 3000, 16000, 29936, 16000, 3000, -1200},
  localparam int HALF   = (TAPS + 1) / 2,
  localparam int PRE_W  = IN_W + 1,
  localparam int PROD_W = PRE_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(HALF)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pre_valid,
  input  logic signed [PRE_W-1:0] pre [HALF],
  output logic                    acc_valid,
  output logic signed [ACC_W-1:0] acc
);

  logic                     prod_valid;
  logic signed [PROD_W-1:0] prod [HALF];
  logic signed [ACC_W-1:0]  acc_c;

  for (genvar j = 0; j < HALF; j++) begin : g_mul
    localparam logic signed [COEF_W-1:0] C =
      COEF_W'(sym_fir_pkg::quant_coef(BASE_COEF[j], COEF_W));
    always_ff @(posedge clk) begin
      if (rst)            prod[j] <= '0;
      else if (pre_valid) prod[j] <= pre[j] * C;
    end
  end

  always_comb begin
    acc_c = '0;
    for (int j = 0; j < HALF; j++) acc_c = acc_c + ACC_W'(prod[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_valid <= 1'b0;
      acc_valid  <= 1'b0;
      acc        <= '0;
    end else begin
      prod_valid <= pre_valid;
      acc_valid  <= prod_valid;
      if (prod_valid) acc <= acc_c;
    end
  end

endmodule

// File: rtl/sym_fir_out.sv
module sym_fir_out #(
  parameter int ACC_W = 31,
  parameter int OUT_W = 14,
  parameter int SHIFT = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_valid,
  input  logic signed [ACC_W-1:0] acc,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam logic signed [ACC_W:0] HALF_LSB = (ACC_W+1)'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W:0] MAX_V    = (ACC_W+1)'((1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W:0] MIN_V    = -MAX_V - (ACC_W+1)'(1);

  logic signed [ACC_W:0]   rnd;
  logic signed [ACC_W:0]   scaled;
  logic signed [OUT_W-1:0] clamped;

  always_comb begin
    rnd    = $signed({acc[ACC_W-1], acc}) + HALF_LSB;
    scaled = rnd >>> SHIFT;
    if (scaled > MAX_V)      clamped = {1'b0, {(OUT_W-1){1'b1}}};
    else if (scaled < MIN_V) clamped = {1'b1, {(OUT_W-1){1'b0}}};
    else                     clamped = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) out_data <= clamped;
    end
  end

  // R1: outputs are cleared right after a reset edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));

  // R3: output value is held between strobes
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data));

endmodule

// File: rtl/sym_fir.sv
module sym_fir #(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 14,
  parameter int COEF_W = 16,
  parameter int TAPS   = 7,
  parameter int BASE_COEF [TAPS] = '{-1200, 3000, 16000, 29936, 16000, 3000, -1200}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int HALF   = (TAPS + 1) / 2;
  localparam int PRE_W  = IN_W + 1;
  localparam int ACC_W  = PRE_W + COEF_W + $clog2(HALF);
  localparam int SHIFT  = COEF_W - (OUT_W - IN_W);

  if (COEF_W > sym_fir_pkg::BASE_COEF_W || SHIFT < 1) begin : g_bad_cfg
    $error("sym_fir: COEF_W out of supported range");
  end

  logic                    tap_valid, pre_valid, acc_valid;
  logic signed [IN_W-1:0]  taps [TAPS];
  logic signed [PRE_W-1:0] pre  [HALF];
  logic signed [ACC_W-1:0] acc;

  sym_fir_taps #(.IN_W(IN_W), .TAPS(TAPS)) u_taps (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .tap_valid(tap_valid), .taps(taps)
  );

  sym_fir_preadd #(.IN_W(IN_W), .TAPS(TAPS)) u_preadd (
    .clk(clk), .rst(rst), .tap_valid(tap_valid), .taps(taps),
    .pre_valid(pre_valid), .pre(pre)
  );

  sym_fir_mac #(.IN_W(IN_W), .TAPS(TAPS), .COEF_W(COEF_W), .BASE_COEF(BASE_COEF)) u_mac (
    .clk(clk), .rst(rst), .pre_valid(pre_valid), .pre(pre),
    .acc_valid(acc_valid), .acc(acc)
  );

  sym_fir_out #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_out (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc(acc),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Cycles since reset, so the latency check never looks back past reset.
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R2: one output strobe per accepted sample, five edges later
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

endmodule

// File: tb/sym_fir_bench.sv
`timescale 1ns/1ps
module sym_fir_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [11:0] in_data = '0;
  logic               o16_valid, o8_valid;
  logic signed [13:0] o16_data, o8_data;

  sym_fir u_sym_fir (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(o16_valid), .out_data(o16_data)
  );

  sym_fir #(.COEF_W(8)) u_sym_fir_c8 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(o8_valid), .out_data(o8_data)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  localparam int C16 [7] = '{-1200, 3000, 16000, 29936, 16000, 3000, -1200};
  localparam int VEC [40] = '{
    2047, 0, 0, 0, 0, 0, 0, 0,
    1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000,
    -2048, 2047, 2047, 2047, 2047, 2047, -2048,
    2047, -2048, -2048, -2048, -2048, -2048, 2047,
    -1500, -500, 700, 1900, -2048, 2047, 300, -300, 5, -5};

  int hist [7];
  int q16_val[$], q16_cyc[$], q8_val[$], q8_cyc[$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int coef(int k, bit c8);
    return c8 ? ((C16[k] + 128) >>> 8) : C16[k];
  endfunction

  function automatic int model(bit c8);
    longint acc = 0;
    int s = c8 ? 6 : 14;
    for (int k = 0; k < 7; k++) acc += longint'(coef(k, c8)) * longint'(hist[k]);
    acc = (acc + (longint'(1) <<< (s - 1))) >>> s;
    if (acc > 8191) acc = 8191;
    if (acc < -8192) acc = -8192;
    return int'(acc);
  endfunction

  task automatic push(int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 12'(v);
    for (int k = 6; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    q16_val.push_back(model(1'b0)); q16_cyc.push_back(cyc + 5);
    q8_val.push_back(model(1'b1));  q8_cyc.push_back(cyc + 5);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 12'($urandom);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 7; k++) hist[k] = 0;
    q16_val.delete(); q16_cyc.delete(); q8_val.delete(); q8_cyc.delete();
  endtask

  // Output monitor: value (R4/R5, R6 for the 8-bit build) and timing (R2).
  always @(negedge clk) begin
    if (!rst) begin
      if (o16_valid) begin
        if (q16_val.size() == 0) check(1'b0, "R2 extra strobe 16b", 1, 0);
        else begin
          int ev, ec;
          ev = q16_val.pop_front(); ec = q16_cyc.pop_front();
          check(ec == cyc, "R2 latency 16b", cyc, ec);
          check(int'(o16_data) == ev, "R4/R5 value 16b", int'(o16_data), ev);
        end
      end
      if (o8_valid) begin
        if (q8_val.size() == 0) check(1'b0, "R2 extra strobe 8b", 1, 0);
        else begin
          int ev, ec;
          ev = q8_val.pop_front(); ec = q8_cyc.pop_front();
          check(ec == cyc, "R2 latency 8b", cyc, ec);
          check(int'(o8_data) == ev, "R6 value 8b", int'(o8_data), ev);
        end
      end
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int y [7];
    int held;
    for (int k = 0; k < 7; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    check(!o16_valid && o16_data == 0, "R1 reset 16b", int'(o16_data), 0);
    check(!o8_valid && o8_data == 0, "R1 reset 8b", int'(o8_data), 0);

    // Table walk, back-to-back strobes (R2, R4, R5, R6, R7)
    for (int i = 0; i < 40; i++) push(VEC[i]);
    idle(8);
    // Sinusoids, streaming (R4)
    for (int i = 0; i < 64; i++)
      push($rtoi(1500.0 * $sin(6.2831853 * i / 20.0) + 400.0 * $sin(6.2831853 * i / 3.0)));
    idle(8);
    check(q16_val.size() == 0, "R2 missing strobes", q16_val.size(), 0);

    // R7: full-scale patterns pin to the rails
    do_reset();
    for (int i = 0; i < 7; i++) push((i == 0 || i == 6) ? -2048 : 2047);
    idle(8);
    check(o16_data == 14'sd8191, "R7 positive saturation 16b", int'(o16_data), 8191);
    check(o8_data == 14'sd8191, "R7 positive saturation 8b", int'(o8_data), 8191);
    for (int i = 0; i < 7; i++) push((i == 0 || i == 6) ? 2047 : -2048);
    idle(8);
    check(o16_data == -14'sd8192, "R7 negative saturation 16b", int'(o16_data), -8192);
    check(o8_data == -14'sd8192, "R7 negative saturation 8b", int'(o8_data), -8192);

    // R8: impulse walked through the taps, mirrored positions agree
    do_reset();
    @(negedge clk);
    check(!o16_valid && o16_data == 0, "R1 reset after run", int'(o16_data), 0);
    for (int k = 0; k < 7; k++) begin
      push(k == 0 ? 2047 : 0);
      idle(6);
      y[k] = int'(o16_data);
    end
    for (int k = 0; k < 3; k++) check(y[k] == y[6-k], "R8 mirror taps", y[k], y[6-k]);
    check(y[3] == 3740, "R8 centre tap alone", y[3], 3740);
    check(y[0] == -150, "R5 outer coefficient", y[0], -150);

    // R3: idle cycles with noise on the input change nothing
    do_reset();
    push(900); push(-700);
    idle(6);
    held = int'(o16_data);
    for (int i = 0; i < 10; i++) begin
      idle(1);
      check(int'(o16_data) == held && !o16_valid, "R3 hold while idle", int'(o16_data), held);
    end
    push(300);
    idle(8);
    check(q16_val.size() == 0 && q8_val.size() == 0, "R3 history intact", q16_val.size(), 0);

    finish_run();
  end

endmodule